// File: doc/BRIEF.md
# Critical-Conduction Boost Switching Cycle Controller

This block produces the gate-drive pulse for a boost converter that runs at the boundary between continuous and discontinuous conduction. The comparators, error amplifier and gate driver sit outside it. It sees their results as single-bit flags plus a digital control code, and it works in clock cycles throughout. Each on time is timed by a ramp counter. The counter restarts from zero on every pulse and stops at whichever limit comes first: the control code less a fixed offset code, or a hard ramp ceiling.

The next on time starts once the auxiliary winding shows that the inductor has demagnetized. The upper-threshold flag must first be held for a minimum number of cycles, and the lower-threshold flag must then assert. If that sequence never arrives, as at start-up, a restart watchdog forces a pulse after a fixed number of idle cycles. An overcurrent flag ends the pulse cycle by cycle, except in a blanking window right after turn-on. An enable from the fault supervisor stops everything at once. A one-cycle strobe marks the end of each on time.

Top module: `crm_cycle_ctrl`

## Requirements
- R1: A pulse starts on demagnetization only when `zcd_hi` has qualified (see R8) during the current off time and `zcd_lo` is then sampled high. The drive rises on the clock edge that samples `zcd_lo`. `zcd_lo` without a prior qualified `zcd_hi` starts nothing.
- R2: The drive stays high for exactly W = `ctrl_code` − OFFSET clock cycles, when that value lies between 1 and RAMP_MAX.
- R3: A `ctrl_code` at or below OFFSET gives no drive pulse from either start source.
- R4: W is capped at RAMP_MAX cycles for any larger code. The ramp restarts from zero on every pulse, so pulses with equal codes have equal widths.
- R5: If no demagnetization event arrives, the drive rises after exactly RESTART_CYC consecutive enabled low cycles. These are counted from the fall of the drive, or from the first cycle in which `en` is high.
- R6: `cs_trip` has no effect while the ramp count (cycles since the drive rose, the first high cycle being 0) is below BLANK_CYC. From count BLANK_CYC on, a sampled `cs_trip` drops the drive at the next edge, so a trip at count k gives a pulse k+1 cycles wide.
- R7: While `en` is low: the drive falls at the next edge; the restart count is held at zero; and any qualified `zcd_hi` is discarded. When `en` deasserts in the same cycle as a start condition, the drive stays low.
- R8: `zcd_hi` qualifies only after MINPW_CYC consecutive high samples while the drive is low. A shorter excursion followed by `zcd_lo` starts nothing.
- R9: `cyc_done` is high for exactly the one cycle after each falling edge of the drive, and at no other time.
- R10: While `rst_n` is low, `drv` and `cyc_done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable from the fault supervisor |
| ctrl_code | input | CTRL_W | Control level code from the error amplifier |
| zcd_hi | input | 1 | Auxiliary winding above the upper threshold |
| zcd_lo | input | 1 | Auxiliary winding below the lower threshold |
| cs_trip | input | 1 | Current-sense comparator tripped |
| drv | output | 1 | Gate-drive command |
| cyc_done | output | 1 | One-cycle strobe at the end of an on time |

## Verification
All inputs are sampled at the rising edge, so every reaction is due at the following edge. A `zcd_lo` presented in one cycle shows as a high drive in the next. A late `cs_trip` or a falling `en` shows as a low drive one cycle later. `cyc_done` is due in the first low cycle. The bench drives inputs and samples outputs on the falling clock edge, so it reads each output half a cycle after the edge that made it. Pulse widths and restart gaps are counted in those falling-edge samples, which gives W high samples and RESTART_CYC low samples directly.

// File: rtl/crm_pkg.sv
package crm_pkg;

  // Pulse width in cycles for a control code: zero at or below the offset,
  // capped at the ramp ceiling.
  function automatic int on_width(int code, int offs, int cap);
    int span;
    if (code <= offs) return 0;
    span = code - offs;
    if (span > cap) return cap;
    return span;
  endfunction

  // Counter width able to hold values 0..n
  function automatic int cnt_bits(int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/crm_demag_det.sv
module crm_demag_det #(
  parameter int MINPW_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic drv,
  input  logic zcd_hi,
  input  logic zcd_lo,
  output logic demag_evt
);
  localparam int CW = crm_pkg::cnt_bits(MINPW_CYC);
  localparam logic [CW-1:0] HI_LAST = CW'(MINPW_CYC - 1);
  localparam logic [CW-1:0] HI_SAT  = CW'(MINPW_CYC);

  logic [CW-1:0] hi_run;
  logic          armed;
  logic          idle;

  assign idle      = en & ~drv;
  assign demag_evt = idle & armed & zcd_lo;

  // Consecutive upper-threshold samples during the off time
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      hi_run <= '0;
    else if (!idle || !zcd_hi)       hi_run <= '0;
    else if (hi_run != HI_SAT)       hi_run <= hi_run + 1'b1;
  end

  // Arm once the excursion is long enough; consumed by the event
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          armed <= 1'b0;
    else if (!idle || demag_evt)         armed <= 1'b0;
    else if (zcd_hi && hi_run == HI_LAST) armed <= 1'b1;
  end

endmodule

// File: rtl/crm_restart_wdog.sv
module crm_restart_wdog #(
  parameter int RESTART_CYC = 9000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic drv,
  output logic wdog_evt
);
  localparam int CW = crm_pkg::cnt_bits(RESTART_CYC);
  localparam logic [CW-1:0] OFF_LAST = CW'(RESTART_CYC - 1);

  logic [CW-1:0] off_run;
  logic          idle;

  assign idle     = en & ~drv;
  assign wdog_evt = idle & (off_run == OFF_LAST);

  // Saturating count of enabled off cycles
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 off_run <= '0;
    else if (!idle)             off_run <= '0;
    else if (off_run != OFF_LAST) off_run <= off_run + 1'b1;
  end

endmodule

// File: rtl/crm_ontime.sv
module crm_ontime #(
  parameter int CTRL_W    = 8,
  parameter int OFFSET    = 40,
  parameter int RAMP_MAX  = 200,
  parameter int BLANK_CYC = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [CTRL_W-1:0] ctrl_code,
  input  logic              start_req,
  input  logic              cs_trip,
  output logic              drv,
  output logic              cyc_done,
  output logic              ramp_end,
  output logic              oc_hit
);
  localparam int RW = crm_pkg::cnt_bits(RAMP_MAX);

  logic [RW-1:0] ramp_q;
  logic [RW-1:0] width_c;
  logic [RW:0]   ramp_inc;
  logic          drv_q;
  logic          done_q;
  logic          set_c;
  logic          drv_nxt;

  assign width_c  = RW'(crm_pkg::on_width(32'(ctrl_code), OFFSET, RAMP_MAX));
  assign ramp_inc = {1'b0, ramp_q} + 1'b1;

  assign set_c    = start_req & ~drv_q & (width_c != '0);
  assign ramp_end = drv_q & (ramp_inc >= {1'b0, width_c});
  assign oc_hit   = drv_q & cs_trip & (32'(ramp_q) >= BLANK_CYC);

  // Reset-dominant: disable wins over any set
  assign drv_nxt  = ((drv_q & ~ramp_end & ~oc_hit) | set_c) & en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drv_q  <= 1'b0;
      ramp_q <= '0;
      done_q <= 1'b0;
    end else begin
      drv_q  <= drv_nxt;
      ramp_q <= (drv_q & drv_nxt) ? RW'(ramp_inc) : '0;
      done_q <= drv_q & ~drv_nxt;
    end
  end

  assign drv      = drv_q;
  assign cyc_done = done_q;

endmodule

// File: rtl/crm_cycle_ctrl.sv
module crm_cycle_ctrl #(
  parameter int CTRL_W      = 8,
  parameter int OFFSET      = 40,
  parameter int RAMP_MAX    = 200,
  parameter int BLANK_CYC   = 13,
  parameter int RESTART_CYC = 9000,
  parameter int MINPW_CYC   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [CTRL_W-1:0] ctrl_code,
  input  logic              zcd_hi,
  input  logic              zcd_lo,
  input  logic              cs_trip,
  output logic              drv,
  output logic              cyc_done
);
  // Internal events, named for the checker
  logic demag_evt;
  logic wdog_evt;
  logic start_req;
  logic ramp_end;
  logic oc_hit;

  assign start_req = demag_evt | wdog_evt;

  crm_demag_det #(.MINPW_CYC(MINPW_CYC)) u_demag (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .drv       (drv),
    .zcd_hi    (zcd_hi),
    .zcd_lo    (zcd_lo),
    .demag_evt (demag_evt)
  );

  crm_restart_wdog #(.RESTART_CYC(RESTART_CYC)) u_wdog (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .drv      (drv),
    .wdog_evt (wdog_evt)
  );

  crm_ontime #(
    .CTRL_W    (CTRL_W),
    .OFFSET    (OFFSET),
    .RAMP_MAX  (RAMP_MAX),
    .BLANK_CYC (BLANK_CYC)
  ) u_ontime (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .ctrl_code (ctrl_code),
    .start_req (start_req),
    .cs_trip   (cs_trip),
    .drv       (drv),
    .cyc_done  (cyc_done),
    .ramp_end  (ramp_end),
    .oc_hit    (oc_hit)
  );

endmodule

// File: rtl/crm_cycle_ctrl_chk.sv
module crm_cycle_ctrl_chk #(
  parameter int CTRL_W      = 8,
  parameter int OFFSET      = 40,
  parameter int RAMP_MAX    = 200,
  parameter int BLANK_CYC   = 13,
  parameter int RESTART_CYC = 9000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en,
  input logic [CTRL_W-1:0] ctrl_code,
  input logic              zcd_hi,
  input logic              zcd_lo,
  input logic              cs_trip,
  input logic              drv,
  input logic              cyc_done,
  input logic              demag_evt
);
  int  hi_len;
  int  off_len;
  logic saw_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_len  <= 0;
      off_len <= 0;
      saw_hi  <= 1'b0;
    end else begin
      hi_len  <= drv ? hi_len + 1 : 0;
      if (en && !drv) off_len <= (off_len < RESTART_CYC) ? off_len + 1 : off_len;
      else            off_len <= 0;
      if (!en || drv)  saw_hi <= 1'b0;
      else if (zcd_hi) saw_hi <= 1'b1;
    end
  end

  assert_start_source_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drv) |-> (off_len >= RESTART_CYC) || ($past(zcd_lo) && $past(saw_hi)));

  assert_no_pulse_low_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!drv && 32'(ctrl_code) <= OFFSET) |=> !drv);

  assert_width_cap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    drv |-> hi_len < RAMP_MAX);

  assert_restart_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(drv) && !$past(demag_evt)) |-> off_len >= RESTART_CYC);

  assert_oc_cut_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (drv && cs_trip && hi_len >= BLANK_CYC) |=> !drv);

  assert_disable_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !drv);

  assert_done_on_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(drv) |-> cyc_done);

  assert_done_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_done |-> $fell(drv));

endmodule

bind crm_cycle_ctrl crm_cycle_ctrl_chk #(
  .CTRL_W      (CTRL_W),
  .OFFSET      (OFFSET),
  .RAMP_MAX    (RAMP_MAX),
  .BLANK_CYC   (BLANK_CYC),
  .RESTART_CYC (RESTART_CYC)
) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .en        (en),
  .ctrl_code (ctrl_code),
  .zcd_hi    (zcd_hi),
  .zcd_lo    (zcd_lo),
  .cs_trip   (cs_trip),
  .drv       (drv),
  .cyc_done  (cyc_done),
  .demag_evt (demag_evt)
);

// File: tb/test_crm_cycle_ctrl.sv
module test_crm_cycle_ctrl;
  localparam int CW    = 8;
  localparam int OFFS  = 40;
  localparam int RMAX  = 100;
  localparam int BLANK = 13;
  localparam int RCYC  = 300;
  localparam int MINPW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          en = 1'b0;
  logic [CW-1:0] ctrl_code = '0;
  logic          zcd_hi = 1'b0;
  logic          zcd_lo = 1'b0;
  logic          cs_trip = 1'b0;
  logic          drv;
  logic          cyc_done;

  int n_cmp = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  crm_cycle_ctrl #(
    .CTRL_W(CW), .OFFSET(OFFS), .RAMP_MAX(RMAX),
    .BLANK_CYC(BLANK), .RESTART_CYC(RCYC), .MINPW_CYC(MINPW)
  ) i_crm_cycle_ctrl (
    .clk(clk), .rst_n(rst_n), .en(en), .ctrl_code(ctrl_code),
    .zcd_hi(zcd_hi), .zcd_lo(zcd_lo), .cs_trip(cs_trip),
    .drv(drv), .cyc_done(cyc_done)
  );

  function automatic int exp_width(int code);
    int w = code - OFFS;
    if (w < 0) w = 0;
    if (w > RMAX) w = RMAX;
    return w;
  endfunction

  task automatic check(string req, int act, int expv);
    n_cmp++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  // Counts low samples, then high samples; ends on the first low sample
  task automatic measure(output int lo, output int hi);
    lo = 0; hi = 0;
    while (drv == 1'b0 && lo < 5000) begin lo++; @(negedge clk); end
    while (drv == 1'b1 && hi < 5000) begin hi++; @(negedge clk); end
  endtask

  task automatic count_high(int n, output int highs);
    highs = 0;
    for (int i = 0; i < n; i++) begin
      if (drv) highs++;
      @(negedge clk);
    end
  endtask

  task automatic arm_zcd(int len);
    zcd_hi = 1'b1; step(len); zcd_hi = 1'b0;
  endtask

  // Trip cs_trip for one sample at high-sample index 'at'; returns width
  task automatic oc_pulse(int at, output int hi);
    while (!drv) @(negedge clk);
    hi = 0;
    while (drv && hi < 5000) begin
      cs_trip = (hi == at);
      hi++;
      @(negedge clk);
    end
    cs_trip = 1'b0;
  endtask

  task automatic t_reset;
    step(4);
    check("R10 drv in reset", int'(drv), 0);
    check("R10 done in reset", int'(cyc_done), 0);
    rst_n = 1'b1;
    step(3);
    check("R7 drv idle while disabled", int'(drv), 0);
  endtask

  task automatic t_startup;
    int lo, hi;
    ctrl_code = 8'd90;
    en = 1'b1;
    measure(lo, hi);
    check("R5 restart from enable", lo, RCYC);
    check("R2 width code 90", hi, exp_width(90));
    measure(lo, hi);
    check("R5 restart after fall", lo, RCYC);
    check("R4 repeat width equal", hi, exp_width(90));
  endtask

  task automatic t_demag;
    int lo, hi;
    ctrl_code = 8'd70;
    arm_zcd(6);
    zcd_lo = 1'b1;
    step(1);
    check("R1 start one edge after zcd_lo", int'(drv), 1);
    zcd_lo = 1'b0;
    measure(lo, hi);
    check("R2 width code 70", hi, exp_width(70));
  endtask

  task automatic t_fall_only;
    int h, lo, hi;
    zcd_lo = 1'b1;
    count_high(40, h);
    check("R1 zcd_lo alone ignored", h, 0);
    zcd_lo = 1'b0;
    measure(lo, hi);
  endtask

  task automatic t_minpw;
    int h, lo, hi;
    arm_zcd(MINPW - 1);
    zcd_lo = 1'b1;
    count_high(20, h);
    check("R8 short excursion ignored", h, 0);
    zcd_lo = 1'b0;
    arm_zcd(MINPW);
    zcd_lo = 1'b1;
    step(1);
    check("R8 minimum excursion accepted", int'(drv), 1);
    zcd_lo = 1'b0;
    measure(lo, hi);
  endtask

  task automatic t_ctrl_low;
    int h, lo, hi;
    ctrl_code = 8'd40;
    arm_zcd(6);
    zcd_lo = 1'b1; step(1); zcd_lo = 1'b0;
    count_high(2 * RCYC + 20, h);
    check("R3 no pulse at offset", h, 0);
    ctrl_code = 8'd41;
    measure(lo, hi);
    check("R2 one-cycle pulse at offset+1", hi, exp_width(41));
  endtask

  task automatic t_cap;
    int lo, hi;
    ctrl_code = 8'd255;
    measure(lo, hi);
    check("R4 cap at full code", hi, RMAX);
    ctrl_code = 8'd140;
    measure(lo, hi);
    check("R4 cap at exact ceiling", hi, RMAX);
    ctrl_code = 8'd139;
    measure(lo, hi);
    check("R4 below ceiling", hi, exp_width(139));
  endtask

  task automatic t_oc;
    int lo, hi;
    ctrl_code = 8'd90;
    cs_trip = 1'b1;
    measure(lo, hi);
    cs_trip = 1'b0;
    check("R6 held trip ends after blank", hi, BLANK + 1);
    oc_pulse(BLANK - 1, hi);
    check("R6 trip in last blank cycle ignored", hi, exp_width(90));
    oc_pulse(BLANK, hi);
    check("R6 trip at first open cycle", hi, BLANK + 1);
    oc_pulse(20, hi);
    check("R6 late trip", hi, 21);
  endtask

  task automatic t_done;
    int lo, hi;
    while (!drv) @(negedge clk);
    check("R9 no strobe while high", int'(cyc_done), 0);
    measure(lo, hi);
    check("R9 strobe after fall", int'(cyc_done), 1);
    step(1);
    check("R9 strobe one cycle", int'(cyc_done), 0);
  endtask

  task automatic t_disable;
    int h, lo, hi;
    while (!drv) @(negedge clk);
    step(5);
    en = 1'b0;
    step(1);
    check("R7 drive drops on disable", int'(drv), 0);
    check("R9 strobe on disable", int'(cyc_done), 1);
    count_high(2 * RCYC + 20, h);
    check("R7 restart held while disabled", h, 0);
    en = 1'b1;
    arm_zcd(6);
    zcd_lo = 1'b1;
    en = 1'b0;
    step(1);
    check("R7 disable beats start", int'(drv), 0);
    en = 1'b1;
    count_high(10, h);
    check("R7 arm discarded by disable", h, 0);
    zcd_lo = 1'b0;
    en = 1'b0;
    step(2);
    en = 1'b1;
    measure(lo, hi);
    check("R7 restart rearmed from enable", lo, RCYC);
  endtask

  initial begin
    t_reset();
    t_startup();
    t_demag();
    t_fall_only();
    t_minpw();
    t_ctrl_low();
    t_cap();
    t_oc();
    t_done();
    t_disable();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule